// File: doc/BRIEF.md
# UART Command Register Decoder

This block sits behind the byte-wide command register of a UART. Each write carries two independent parts. The low four bits switch the receiver and the transmitter on or off. The high nibble selects at most one miscellaneous command. The block turns each accepted write into registered level controls and one-cycle pulses. The transmitter, receiver, error-status logic, modem-control pin and counter/timer sample these outputs. The block does not contain the serial datapaths, FIFOs or counter/timer.

Miscellaneous commands must be spaced apart by a minimum number of reference clock edges. The reference clock is seen as a one-cycle `ref_edge` strobe in the system clock domain. A command that arrives too early is dropped and raises a sticky violation flag. In power-down, every write is ignored except the power-down-off command, and all held levels keep their values.

Top module: `uart_cmd_decoder`

## Requirements
- R1: Write bit 0 enables the receiver and bit 1 disables it. Bit 2 enables the transmitter and bit 3 disables it. If enable and disable for one direction arrive in the same write, the disable wins. `rx_enable`/`tx_enable` show the new value one cycle after the write.
- R2: After reset, these outputs are low: `rx_enable`, `tx_enable`, `timeout_mode`, `power_down`, `spacing_err` and all pulses. `rts_n` is high and `mr_ptr` is 0.
- R3: Nibble 0x2 pulses `rx_reset_p` and clears `rx_enable`. Nibble 0x3 pulses `tx_reset_p` and clears `tx_enable`. Nibble 0x4 pulses `err_clear_p`, one strobe that clears all four receive error flags. Nibble 0x5 pulses `brk_chg_clear_p`.
- R4: Nibble 0x6 pulses `break_start_p` only if the transmitter was enabled when the write arrived; otherwise it does nothing. Nibble 0x7 pulses `break_stop_p`.
- R5: Nibble 0x8 drives `rts_n` low and nibble 0x9 drives it high. Both are held levels.
- R6: Nibble 0xA sets `timeout_mode` and nibble 0xC clears it.
- R7: Nibble 0x1 sets `mr_ptr` to 1 and nibble 0xB sets it to 0.
- R8: Nibble 0x0 and nibble 0xD change no output. Nibble 0xD still counts as a command for spacing.
- R9: A nonzero nibble is accepted only after at least MIN_GAP (default 3) `ref_edge` strobes since the previous accepted command. An early command is dropped and sets `spacing_err`, which stays set until reset. The low four bits of that write still apply.
- R10: Nibble 0xE sets `power_down`. While it is set, every write other than nibble 0xF has no effect, including its low bits. Nibble 0xF clears `power_down`.
- R11: At most one command pulse is high in any cycle. Each pulse lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_edge | input | 1 | One-cycle strobe per reference clock edge |
| wr_en | input | 1 | Command register write strobe |
| wr_data | input | 8 | Command byte |
| rx_enable | output | 1 | Receiver enable level |
| tx_enable | output | 1 | Transmitter enable level |
| rx_reset_p | output | 1 | Receiver reset pulse |
| tx_reset_p | output | 1 | Transmitter reset pulse |
| err_clear_p | output | 1 | Clear-all-error-flags pulse |
| brk_chg_clear_p | output | 1 | Clear break-change interrupt pulse |
| break_start_p | output | 1 | Start-break pulse |
| break_stop_p | output | 1 | Stop-break pulse |
| rts_n | output | 1 | Request-to-send, active low |
| timeout_mode | output | 1 | Receive timeout mode level |
| power_down | output | 1 | Power-down level |
| mr_ptr | output | 2 | Mode register pointer |
| spacing_err | output | 1 | Sticky spacing violation flag |

## Verification
Every result is registered once: levels, pulses and the violation flag all change on the first clock edge after the write cycle. Each pulse falls on the edge after that. The bench drives a write at a falling edge and samples every output at the next falling edge. It then samples once more one cycle later to confirm that every pulse has dropped. The spacing counter only counts strobes from cycles before the write, so the bench sends an exact number of `ref_edge` strobes before each write: either MIN_GAP, or fewer to reach the boundary case.

// File: rtl/ucd_pkg.sv
package ucd_pkg;

  typedef enum logic [3:0] {
    MC_NOP       = 4'h0,
    MC_PTR_ONE   = 4'h1,
    MC_RX_RST    = 4'h2,
    MC_TX_RST    = 4'h3,
    MC_ERR_CLR   = 4'h4,
    MC_BRKCHG    = 4'h5,
    MC_BRK_START = 4'h6,
    MC_BRK_STOP  = 4'h7,
    MC_RTS_ON    = 4'h8,
    MC_RTS_OFF   = 4'h9,
    MC_TMO_ON    = 4'hA,
    MC_PTR_ZERO  = 4'hB,
    MC_TMO_OFF   = 4'hC,
    MC_SPARE     = 4'hD,
    MC_PD_ON     = 4'hE,
    MC_PD_OFF    = 4'hF
  } misc_code_e;

  typedef struct packed {
    logic rx_rst;
    logic tx_rst;
    logic err_clr;
    logic brkchg_clr;
    logic brk_start;
    logic brk_stop;
    logic rts_on;
    logic rts_off;
    logic tmo_on;
    logic tmo_off;
    logic ptr_one;
    logic ptr_zero;
    logic pd_on;
    logic pd_off;
  } misc_req_t;

  localparam int PULSE_W     = 6;
  localparam int P_RX_RST    = 0;
  localparam int P_TX_RST    = 1;
  localparam int P_ERR_CLR   = 2;
  localparam int P_BRKCHG    = 3;
  localparam int P_BRK_START = 4;
  localparam int P_BRK_STOP  = 5;

  // One-hot request for a nibble; NOP and SPARE give no request.
  function automatic misc_req_t decode_misc(input logic [3:0] code);
    misc_req_t r;
    r = '0;
    case (misc_code_e'(code))
      MC_PTR_ONE:   r.ptr_one    = 1'b1;
      MC_RX_RST:    r.rx_rst     = 1'b1;
      MC_TX_RST:    r.tx_rst     = 1'b1;
      MC_ERR_CLR:   r.err_clr    = 1'b1;
      MC_BRKCHG:    r.brkchg_clr = 1'b1;
      MC_BRK_START: r.brk_start  = 1'b1;
      MC_BRK_STOP:  r.brk_stop   = 1'b1;
      MC_RTS_ON:    r.rts_on     = 1'b1;
      MC_RTS_OFF:   r.rts_off    = 1'b1;
      MC_TMO_ON:    r.tmo_on     = 1'b1;
      MC_PTR_ZERO:  r.ptr_zero   = 1'b1;
      MC_TMO_OFF:   r.tmo_off    = 1'b1;
      MC_PD_ON:     r.pd_on      = 1'b1;
      MC_PD_OFF:    r.pd_off     = 1'b1;
      default:      r = '0;
    endcase
    return r;
  endfunction

  // Enable/disable pair on a held level: disable takes priority.
  function automatic logic next_enable(input logic cur, input logic en,
                                       input logic dis);
    if (dis)     return 1'b0;
    else if (en) return 1'b1;
    else         return cur;
  endfunction

endpackage

// File: rtl/ucd_gap_guard.sv
module ucd_gap_guard #(
  parameter int MIN_GAP = 3,
  localparam int CW = $clog2(MIN_GAP + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_edge,
  input  logic cmd_accept,
  output logic gap_ok
);

  localparam logic [CW-1:0] GAP_LIM = CW'(MIN_GAP);

  logic [CW-1:0] edge_cnt;

  // Saturating count of reference edges since the last accepted command.
  always_ff @(posedge clk) begin
    if (!rst_n)                           edge_cnt <= GAP_LIM;
    else if (cmd_accept)                  edge_cnt <= '0;
    else if (ref_edge && edge_cnt != GAP_LIM) edge_cnt <= edge_cnt + 1'b1;
  end

  assign gap_ok = (edge_cnt >= GAP_LIM);

  // R9: the counter never runs past its limit.
  a_r9_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    edge_cnt <= GAP_LIM);

  // R9: an accepted command closes the window for the next cycle.
  a_r9_window_closes: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_accept |=> !gap_ok);

endmodule

// File: rtl/ucd_nibble_decode.sv
module ucd_nibble_decode
  import ucd_pkg::*;
(
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       power_down,
  input  logic       gap_ok,
  output misc_req_t  req,
  output logic       misc_fire,
  output logic       misc_reject,
  output logic       lo_rx_en,
  output logic       lo_rx_dis,
  output logic       lo_tx_en,
  output logic       lo_tx_dis
);

  logic [3:0] code;
  logic       is_misc;
  logic       pd_block;
  logic       low_live;

  assign code     = wr_data[7:4];
  assign is_misc  = wr_en && (code != MC_NOP);
  assign pd_block = power_down && (code != MC_PD_OFF);
  assign low_live = wr_en && !power_down;

  assign misc_fire   = is_misc && !pd_block && gap_ok;
  assign misc_reject = is_misc && !pd_block && !gap_ok;

  assign req = misc_fire ? decode_misc(code) : '0;

  assign lo_rx_en  = low_live && wr_data[0];
  assign lo_rx_dis = low_live && wr_data[1];
  assign lo_tx_en  = low_live && wr_data[2];
  assign lo_tx_dis = low_live && wr_data[3];

  // R11: one accepted nibble yields at most one request.
  always_comb begin
    a_r11_req_onehot: assert ($onehot0(req));
  end

endmodule

// File: rtl/ucd_ctrl_regs.sv
module ucd_ctrl_regs
  import ucd_pkg::*;
#(
  parameter int PTR_W = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  misc_req_t           req,
  input  logic                misc_reject,
  input  logic                lo_rx_en,
  input  logic                lo_rx_dis,
  input  logic                lo_tx_en,
  input  logic                lo_tx_dis,
  output logic                rx_en,
  output logic                tx_en,
  output logic                rts_n,
  output logic                tmo_mode,
  output logic                pd,
  output logic [PTR_W-1:0]    mr_ptr,
  output logic [PULSE_W-1:0]  pulse,
  output logic                viol
);

  logic [PULSE_W-1:0] pulse_d;
  logic               rx_en_d;
  logic               tx_en_d;

  always_comb begin
    pulse_d              = '0;
    pulse_d[P_RX_RST]    = req.rx_rst;
    pulse_d[P_TX_RST]    = req.tx_rst;
    pulse_d[P_ERR_CLR]   = req.err_clr;
    pulse_d[P_BRKCHG]    = req.brkchg_clr;
    pulse_d[P_BRK_START] = req.brk_start && tx_en;
    pulse_d[P_BRK_STOP]  = req.brk_stop;
  end

  assign rx_en_d = req.rx_rst ? 1'b0 : next_enable(rx_en, lo_rx_en, lo_rx_dis);
  assign tx_en_d = req.tx_rst ? 1'b0 : next_enable(tx_en, lo_tx_en, lo_tx_dis);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_en    <= 1'b0;
      tx_en    <= 1'b0;
      rts_n    <= 1'b1;
      tmo_mode <= 1'b0;
      pd       <= 1'b0;
      mr_ptr   <= '0;
      pulse    <= '0;
      viol     <= 1'b0;
    end else begin
      rx_en <= rx_en_d;
      tx_en <= tx_en_d;
      pulse <= pulse_d;
      if (req.rts_on)   rts_n    <= 1'b0;
      if (req.rts_off)  rts_n    <= 1'b1;
      if (req.tmo_on)   tmo_mode <= 1'b1;
      if (req.tmo_off)  tmo_mode <= 1'b0;
      if (req.pd_on)    pd       <= 1'b1;
      if (req.pd_off)   pd       <= 1'b0;
      if (req.ptr_one)  mr_ptr   <= PTR_W'(1);
      if (req.ptr_zero) mr_ptr   <= '0;
      if (misc_reject)  viol     <= 1'b1;
    end
  end

  // R1: disable beats any enable in the same write.
  a_r1_rx_dis_wins: assert property (@(posedge clk) disable iff (!rst_n)
    lo_rx_dis |=> !rx_en);
  a_r1_tx_dis_wins: assert property (@(posedge clk) disable iff (!rst_n)
    lo_tx_dis |=> !tx_en);

  // R4: a break only starts from an enabled transmitter.
  a_r4_break_gated: assert property (@(posedge clk) disable iff (!rst_n)
    pulse[P_BRK_START] |-> $past(tx_en));

  // R11: pulses are mutually exclusive and last one cycle.
  a_r11_pulse_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pulse));
  a_r11_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    (|pulse) |=> !(|pulse));

  // R9: the violation flag is sticky.
  a_r9_viol_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    viol |=> viol);

endmodule

// File: rtl/uart_cmd_decoder.sv
module uart_cmd_decoder
  import ucd_pkg::*;
#(
  parameter int MIN_GAP = 3,
  parameter int PTR_W   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_edge,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  output logic             rx_enable,
  output logic             tx_enable,
  output logic             rx_reset_p,
  output logic             tx_reset_p,
  output logic             err_clear_p,
  output logic             brk_chg_clear_p,
  output logic             break_start_p,
  output logic             break_stop_p,
  output logic             rts_n,
  output logic             timeout_mode,
  output logic             power_down,
  output logic [PTR_W-1:0] mr_ptr,
  output logic             spacing_err
);

  misc_req_t          req;
  logic               gap_ok;
  logic               misc_fire;
  logic               misc_reject;
  logic               lo_rx_en;
  logic               lo_rx_dis;
  logic               lo_tx_en;
  logic               lo_tx_dis;
  logic [PULSE_W-1:0] pulse;

  ucd_gap_guard #(.MIN_GAP(MIN_GAP)) u_gap (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_edge   (ref_edge),
    .cmd_accept (misc_fire),
    .gap_ok     (gap_ok)
  );

  ucd_nibble_decode u_dec (
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .power_down  (power_down),
    .gap_ok      (gap_ok),
    .req         (req),
    .misc_fire   (misc_fire),
    .misc_reject (misc_reject),
    .lo_rx_en    (lo_rx_en),
    .lo_rx_dis   (lo_rx_dis),
    .lo_tx_en    (lo_tx_en),
    .lo_tx_dis   (lo_tx_dis)
  );

  ucd_ctrl_regs #(.PTR_W(PTR_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .req         (req),
    .misc_reject (misc_reject),
    .lo_rx_en    (lo_rx_en),
    .lo_rx_dis   (lo_rx_dis),
    .lo_tx_en    (lo_tx_en),
    .lo_tx_dis   (lo_tx_dis),
    .rx_en       (rx_enable),
    .tx_en       (tx_enable),
    .rts_n       (rts_n),
    .tmo_mode    (timeout_mode),
    .pd          (power_down),
    .mr_ptr      (mr_ptr),
    .pulse       (pulse),
    .viol        (spacing_err)
  );

  assign rx_reset_p      = pulse[P_RX_RST];
  assign tx_reset_p      = pulse[P_TX_RST];
  assign err_clear_p     = pulse[P_ERR_CLR];
  assign brk_chg_clear_p = pulse[P_BRKCHG];
  assign break_start_p   = pulse[P_BRK_START];
  assign break_stop_p    = pulse[P_BRK_STOP];

  // R10: in power-down, anything but the wake command leaves every output alone.
  a_r10_pd_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (power_down && !(wr_en && wr_data[7:4] == 4'hF)) |=>
      ($stable(rx_enable) && $stable(tx_enable) && $stable(rts_n) &&
       $stable(timeout_mode) && $stable(mr_ptr) && power_down && !(|pulse)));

  // R9: the violation flag only rises after a write.
  a_r9_viol_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spacing_err) |-> $past(wr_en));

  // R2 / R8: a write with an empty nibble produces no pulse.
  a_r8_nop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_data[7:4] == 4'h0 || wr_data[7:4] == 4'hD)) |=> !(|pulse));

endmodule

// File: tb/uart_cmd_decoder_tb.sv
module uart_cmd_decoder_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_edge = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       rx_enable, tx_enable, rx_reset_p, tx_reset_p, err_clear_p;
  logic       brk_chg_clear_p, break_start_p, break_stop_p;
  logic       rts_n, timeout_mode, power_down, spacing_err;
  logic [1:0] mr_ptr;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  uart_cmd_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .ref_edge(ref_edge), .wr_en(wr_en),
    .wr_data(wr_data), .rx_enable(rx_enable), .tx_enable(tx_enable),
    .rx_reset_p(rx_reset_p), .tx_reset_p(tx_reset_p),
    .err_clear_p(err_clear_p), .brk_chg_clear_p(brk_chg_clear_p),
    .break_start_p(break_start_p), .break_stop_p(break_stop_p),
    .rts_n(rts_n), .timeout_mode(timeout_mode), .power_down(power_down),
    .mr_ptr(mr_ptr), .spacing_err(spacing_err)
  );

  // Observation: {pulses[5:0], rx, tx, rts_n, tmo, pd, ptr[1:0], viol}
  // pulse order: [5]stop [4]start [3]brkchg [2]err [1]tx_rst [0]rx_rst
  function automatic logic [13:0] observe();
    return {break_stop_p, break_start_p, brk_chg_clear_p, err_clear_p,
            tx_reset_p, rx_reset_p, rx_enable, tx_enable, rts_n,
            timeout_mode, power_down, mr_ptr, spacing_err};
  endfunction

  function automatic string tag_name(input logic [3:0] t);
    case (t)
      4'd1:  return "R1";
      4'd3:  return "R3";
      4'd4:  return "R4";
      4'd5:  return "R5";
      4'd6:  return "R6";
      4'd7:  return "R7";
      4'd8:  return "R8";
      default: return "R?";
    endcase
  endfunction

  task automatic check(input string req, input logic [13:0] exp);
    logic [13:0] got;
    got = observe();
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  // Strobe n reference edges, write, sample after one edge, then confirm pulses drop.
  task automatic write_cmd(input logic [7:0] d, input int edges,
                           input string req, input logic [13:0] exp);
    for (int i = 0; i < edges; i++) begin
      @(negedge clk); ref_edge = 1'b1;
      @(negedge clk); ref_edge = 1'b0;
    end
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = 8'h00;
    check(req, exp);
    @(negedge clk);
    check("R11", {6'b0, exp[7:0]});
  endtask

  // {data, pulses, rx, tx, rts_n, tmo, pd, ptr, tag}
  localparam int NV = 20;
  localparam logic [24:0] VEC [NV] = '{
    {8'h01, 6'b000000, 5'b10100, 2'd0, 4'd1},
    {8'h04, 6'b000000, 5'b11100, 2'd0, 4'd1},
    {8'h60, 6'b010000, 5'b11100, 2'd0, 4'd4},
    {8'h70, 6'b100000, 5'b11100, 2'd0, 4'd4},
    {8'h20, 6'b000001, 5'b01100, 2'd0, 4'd3},
    {8'h05, 6'b000000, 5'b11100, 2'd0, 4'd1},
    {8'h03, 6'b000000, 5'b01100, 2'd0, 4'd1},
    {8'h40, 6'b000100, 5'b01100, 2'd0, 4'd3},
    {8'h50, 6'b001000, 5'b01100, 2'd0, 4'd3},
    {8'h80, 6'b000000, 5'b01000, 2'd0, 4'd5},
    {8'hA0, 6'b000000, 5'b01010, 2'd0, 4'd6},
    {8'h10, 6'b000000, 5'b01010, 2'd1, 4'd7},
    {8'hB0, 6'b000000, 5'b01010, 2'd0, 4'd7},
    {8'hC0, 6'b000000, 5'b01000, 2'd0, 4'd6},
    {8'h90, 6'b000000, 5'b01100, 2'd0, 4'd5},
    {8'hD0, 6'b000000, 5'b01100, 2'd0, 4'd8},
    {8'h30, 6'b000010, 5'b00100, 2'd0, 4'd3},
    {8'h60, 6'b000000, 5'b00100, 2'd0, 4'd4},
    {8'h0C, 6'b000000, 5'b00100, 2'd0, 4'd1},
    {8'h84, 6'b000000, 5'b01000, 2'd0, 4'd5}
  };

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R2", 14'b000000_00100_00_0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2", 14'b000000_00100_00_0);

    for (int v = 0; v < NV; v++) begin
      write_cmd(VEC[v][24:17], 3, tag_name(VEC[v][3:0]),
                {VEC[v][16:4], 1'b0});
    end

    // R9: spacing boundary. State now rx0 tx1 rts_n0.
    write_cmd(8'h90, 3, "R9", 14'b000000_01100_00_0);
    write_cmd(8'h81, 2, "R9", 14'b000000_11100_00_1); // early: dropped, low bits apply
    write_cmd(8'h80, 1, "R9", 14'b000000_11000_00_1); // third edge: accepted

    // R10: power-down lockout.
    write_cmd(8'hE0, 3, "R10", 14'b000000_11001_00_1);
    write_cmd(8'h92, 3, "R10", 14'b000000_11001_00_1);
    write_cmd(8'h08, 3, "R10", 14'b000000_11001_00_1);
    write_cmd(8'h20, 3, "R10", 14'b000000_11001_00_1);
    write_cmd(8'hF0, 3, "R10", 14'b000000_11000_00_1);
    write_cmd(8'h90, 3, "R10", 14'b000000_11100_00_1);

    // R2: reset mid-run restores the reset state.
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R2", 14'b000000_00100_00_0);
    rst_n = 1'b1;
    // R9: gap counter starts satisfied after reset.
    write_cmd(8'h80, 0, "R9", 14'b000000_00000_00_0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule